// File: doc/BRIEF.md
# Keypad Handshake Link Host Controller

This block is the host end of a two-wire link to a keypad microcontroller. The host drives one line (`txd_o`) and watches one line (`txs_i`). Each data bit moves through a fully interlocked four-phase exchange, and each phase has its own timeout counted in clock cycles. No clocked or framed serial format is used. The incoming line passes through a two-flop synchroniser before the controller acts on it.

After reset the controller holds the link quiet for a long boot delay. It then runs a synchronisation exchange. If the keypad does not answer that exchange correctly, the controller gives up for good and stays unsynchronised until the next reset. Once synchronised, a one-cycle request pulse starts one bit transfer. The result is reported by a one-cycle `done_o` pulse with a data bit and a 2-bit status code.

Top module: `kpad_link_ctrl`

## Requirements
- R1: From reset, `txd_o`, `busy_o` and `done_o` are low. `txd_o` stays low for `BOOT_CYC` cycles after reset release and then goes high to start synchronisation.
- R2: If the synchronised `txs_i` does not go high within `RESP_CYC` cycles of `txd_o` rising, synchronisation is abandoned for good, and `txd_o` stays high.
- R3: After `txs_i` has answered high, it must return low within `CORR_CYC` cycles; otherwise synchronisation is abandoned for good.
- R4: A request made while not synchronised gives `done_o` on the next cycle with status 2'b11 (not synchronised), and `txd_o` is left unchanged.
- R5: If `txs_i` is high when a request is taken, the transfer ends at once with status 2'b01 (foreign device), and `txd_o` stays high.
- R6: On a request with `txs_i` low, `txd_o` goes low (attention). If `txs_i` does not go high within `READY_CYC` cycles, the transfer ends with status 2'b10 (disconnected), and `txd_o` returns high.
- R7: After the synchronised `txs_i` goes high (ready), `txd_o` goes high (start) on the next clock. That is at most three cycles after the pin changes.
- R8: `SETTLE_CYC` cycles after start, the bit is sampled from `txs_i`: a high level gives `data_o` = 0 and a low level gives `data_o` = 1.
- R9: After the sample, `txd_o` goes low (stop) and `txs_i` must go high within `STOP_CYC` cycles. Then `txd_o` goes high (stand easy) and `txs_i` must go low within `IDLE_CYC` cycles. A miss in either phase ends the transfer with status 2'b10.
- R10: A completed transfer reports status 2'b00 with the bit on `data_o`. `done_o` is a single-cycle pulse. `busy_o` is high from the cycle after the request until the `done_o` cycle, and is low in that cycle. The link recovers for the next request after any abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle pulse that starts a bit transfer |
| txs_i | input | 1 | Line from the keypad (asynchronous) |
| txd_o | output | 1 | Line to the keypad |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse; the result is valid |
| data_o | output | 1 | Received bit (meaningful when the status is ok) |
| status_o | output | 2 | 00 ok, 01 foreign device, 10 disconnected, 11 not synchronised |

## Verification
The hardest cases to reach are the timeouts in the middle of a handshake and the permanent abandonment of synchronisation. In these cases the keypad must answer some phases correctly and then fall silent at one exact phase. The bench models the keypad as a scripted task. Per vector, the task can omit the ready, stopped or idle reply, while it answers every earlier phase correctly. Reset is applied again with the sync reply withheld, and again with a reply that never returns low, to reach both ways of abandoning synchronisation.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
  typedef enum logic [1:0] {
    KP_OK      = 2'b00,
    KP_FOREIGN = 2'b01,
    KP_DISC    = 2'b10,
    KP_NOSYNC  = 2'b11
  } kp_status_e;

  typedef enum logic [3:0] {
    S_BOOT, S_PRES, S_CORR, S_DEAD, S_IDLE,
    S_ATTN, S_START, S_STOP, S_EASY
  } kp_state_e;
endpackage

// File: rtl/kpad_sync.sv
module kpad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/kpad_timer.sv
module kpad_timer #(
  parameter int TW      = 32,
  parameter int RST_VAL = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          exp_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= TW'(RST_VAL);
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign exp_o = (cnt_q == '0);

  // R6
  tmr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_o && !load_i |=> exp_o);
endmodule

// File: rtl/kpad_fsm.sv
module kpad_fsm
  import kpad_pkg::*;
#(
  parameter int TW         = 32,
  parameter int RESP_CYC   = 16,
  parameter int CORR_CYC   = 16,
  parameter int READY_CYC  = 16,
  parameter int SETTLE_CYC = 8,
  parameter int STOP_CYC   = 16,
  parameter int IDLE_CYC   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          txs_s_i,
  input  logic          tmr_exp_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          txd_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          data_o,
  output logic [1:0]    status_o
);
  kp_state_e  st_q, st_d;
  logic       txd_d, done_d, data_d;
  kp_status_e stat_q, stat_d;

  always_comb begin
    st_d   = st_q;
    txd_d  = txd_o;
    done_d = 1'b0;
    data_d = data_o;
    stat_d = stat_q;
    unique case (st_q)
      S_BOOT: if (tmr_exp_i) begin txd_d = 1'b1; st_d = S_PRES; end
      S_PRES: if (txs_s_i) st_d = S_CORR;
              else if (tmr_exp_i) st_d = S_DEAD;
      S_CORR: if (!txs_s_i) st_d = S_IDLE;
              else if (tmr_exp_i) st_d = S_DEAD;
      S_DEAD: ;
      S_IDLE: if (req_i) begin
        if (txs_s_i) begin
          done_d = 1'b1; stat_d = KP_FOREIGN; data_d = 1'b0;
        end else begin
          txd_d = 1'b0; st_d = S_ATTN;
        end
      end
      S_ATTN: if (txs_s_i) begin txd_d = 1'b1; st_d = S_START; end
              else if (tmr_exp_i) begin
                txd_d = 1'b1; st_d = S_IDLE;
                done_d = 1'b1; stat_d = KP_DISC; data_d = 1'b0;
              end
      S_START: if (tmr_exp_i) begin
        data_d = ~txs_s_i; txd_d = 1'b0; st_d = S_STOP;
      end
      S_STOP: if (txs_s_i) begin txd_d = 1'b1; st_d = S_EASY; end
              else if (tmr_exp_i) begin
                txd_d = 1'b1; st_d = S_IDLE;
                done_d = 1'b1; stat_d = KP_DISC; data_d = 1'b0;
              end
      S_EASY: if (!txs_s_i) begin
                st_d = S_IDLE; done_d = 1'b1; stat_d = KP_OK;
              end else if (tmr_exp_i) begin
                st_d = S_IDLE;
                done_d = 1'b1; stat_d = KP_DISC; data_d = 1'b0;
              end
      default: st_d = S_DEAD;
    endcase
    // requests outside the synchronised idle state are refused
    if (req_i && (st_q inside {S_BOOT, S_PRES, S_CORR, S_DEAD})) begin
      done_d = 1'b1; stat_d = KP_NOSYNC; data_d = 1'b0;
    end
  end

  always_comb begin
    tmr_load_o = (st_d != st_q);
    unique case (st_d)
      S_PRES:  tmr_val_o = TW'(RESP_CYC);
      S_CORR:  tmr_val_o = TW'(CORR_CYC);
      S_ATTN:  tmr_val_o = TW'(READY_CYC);
      S_START: tmr_val_o = TW'(SETTLE_CYC);
      S_STOP:  tmr_val_o = TW'(STOP_CYC);
      S_EASY:  tmr_val_o = TW'(IDLE_CYC);
      default: tmr_val_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_BOOT;
      txd_o  <= 1'b0;
      done_o <= 1'b0;
      data_o <= 1'b0;
      stat_q <= KP_OK;
    end else begin
      st_q   <= st_d;
      txd_o  <= txd_d;
      done_o <= done_d;
      data_o <= data_d;
      stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;
  assign busy_o   = st_q inside {S_ATTN, S_START, S_STOP, S_EASY};

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R4
  nosync_txd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && status_o == KP_NOSYNC |-> $stable(txd_o));
  // R5
  foreign_txd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && status_o == KP_FOREIGN |-> txd_o && $stable(txd_o));
  // R6
  abort_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && status_o == KP_DISC |-> txd_o);
  // R7
  start_prompt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_ATTN && txs_s_i |=> txd_o);
endmodule

// File: rtl/kpad_link_ctrl.sv
module kpad_link_ctrl #(
  parameter int BOOT_CYC   = 375_000_000,
  parameter int RESP_CYC   = 1_875_000,
  parameter int CORR_CYC   = 125_000,
  parameter int READY_CYC  = 1_875_000,
  parameter int SETTLE_CYC = 16,
  parameter int STOP_CYC   = 1_875_000,
  parameter int IDLE_CYC   = 162_500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       txs_i,
  output logic       txd_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       data_o,
  output logic [1:0] status_o
);
  localparam int M1   = (RESP_CYC > CORR_CYC) ? RESP_CYC : CORR_CYC;
  localparam int M2   = (READY_CYC > STOP_CYC) ? READY_CYC : STOP_CYC;
  localparam int M3   = (IDLE_CYC > SETTLE_CYC) ? IDLE_CYC : SETTLE_CYC;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int M123 = (M12 > M3) ? M12 : M3;
  localparam int MAXC = (M123 > BOOT_CYC) ? M123 : BOOT_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  logic          txs_s, tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;

  kpad_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(txs_i), .q_o(txs_s)
  );

  kpad_timer #(.TW(TW), .RST_VAL(BOOT_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .val_i(tmr_val), .exp_o(tmr_exp)
  );

  kpad_fsm #(
    .TW(TW), .RESP_CYC(RESP_CYC), .CORR_CYC(CORR_CYC),
    .READY_CYC(READY_CYC), .SETTLE_CYC(SETTLE_CYC),
    .STOP_CYC(STOP_CYC), .IDLE_CYC(IDLE_CYC)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .txs_s_i(txs_s),
    .tmr_exp_i(tmr_exp), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .txd_o(txd_o), .busy_o(busy_o), .done_o(done_o),
    .data_o(data_o), .status_o(status_o)
  );
endmodule

// File: tb/kpad_link_ctrl_test.sv
module kpad_link_ctrl_test;
  localparam int BOOT = 60, RESP = 30, CORR = 20, READY = 40;
  localparam int SETTLE = 8, STOPC = 40, IDLEC = 40;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, txs = 1'b0;
  logic txd, busy, done, data;
  logic [1:0] status;
  int   n_tests = 0, n_fail = 0;
  logic [1:0] got_st;
  logic       got_d;
  int         start_lat;

  always #4 clk = ~clk;

  kpad_link_ctrl #(
    .BOOT_CYC(BOOT), .RESP_CYC(RESP), .CORR_CYC(CORR), .READY_CYC(READY),
    .SETTLE_CYC(SETTLE), .STOP_CYC(STOPC), .IDLE_CYC(IDLEC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .txs_i(txs),
    .txd_o(txd), .busy_o(busy), .done_o(done), .data_o(data), .status_o(status)
  );

  // mode: 0 normal, 1 foreign, 2 no ready, 3 no stopped, 4 no idle
  // entry: {mode[2:0], bit, exp_status[1:0]}
  localparam logic [5:0] VEC [7] = '{
    {3'd0, 1'b0, 2'b00}, {3'd0, 1'b1, 2'b00}, {3'd1, 1'b0, 2'b01},
    {3'd2, 1'b0, 2'b10}, {3'd3, 1'b1, 2'b10}, {3'd4, 1'b0, 2'b10},
    {3'd0, 1'b1, 2'b00}
  };

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  task automatic do_req();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    got_st = status;
    got_d  = data;
  endtask

  task automatic kp_serve(input logic [2:0] mode, input logic b);
    wait (txd == 1'b0);
    if (mode == 3'd2) return;
    repeat (3) @(negedge clk);
    txs = 1'b1;
    start_lat = 0;
    while (txd == 1'b0) begin @(negedge clk); start_lat++; end
    repeat (2) @(negedge clk);
    txs = ~b;
    wait (txd == 1'b0);
    if (mode == 3'd3) return;
    repeat (2) @(negedge clk);
    txs = 1'b1;
    wait (txd == 1'b1);
    if (mode == 3'd4) return;
    repeat (2) @(negedge clk);
    txs = 1'b0;
  endtask

  task automatic kp_sync(input bit answer, input bit fall);
    wait (txd == 1'b1);
    if (!answer) return;
    repeat (3) @(negedge clk);
    txs = 1'b1;
    if (!fall) return;
    repeat (4) @(negedge clk);
    txs = 1'b0;
  endtask

  task automatic restart();
    rst_n = 1'b0; txs = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 txd", txd, 0); check("R1 busy", busy, 0); check("R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 request during boot wait
    do_req();
    check("R4 status", got_st, 2'b11);
    check("R4 txd", txd, 0);
    repeat (BOOT - 10) @(negedge clk);
    check("R1 boot hold", txd, 0);
    fork kp_sync(1, 1); join_none
    repeat (15) @(negedge clk);
    check("R1 txd raised", txd, 1);
    repeat (20) @(negedge clk);

    foreach (VEC[k]) begin
      logic [2:0] md;
      logic       kb;
      logic [1:0] es;
      md = VEC[k][5:3]; kb = VEC[k][2]; es = VEC[k][1:0];
      if (md == 3'd1) begin
        txs = 1'b1;
        repeat (4) @(negedge clk);
        do_req();
        check("R5 status", got_st, es);
        check("R5 txd held", txd, 1);
        check("R5 busy", busy, 0);
        txs = 1'b0;
      end else begin
        fork
          kp_serve(md, kb);
          begin
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            check("R10 busy", busy, 1);
            for (int i = 0; i < 400 && !done; i++) @(negedge clk);
            got_st = status; got_d = data;
            check("R10 busy at done", busy, 0);
            @(negedge clk);
            check("R10 done pulse", done, 0);
          end
        join
        if (md == 3'd0) begin
          check("R10 status", got_st, 2'b00);
          check("R8 data", got_d, kb);
          check("R7 start latency", start_lat <= 3, 1);
        end else if (md == 3'd2) begin
          check("R6 status", got_st, es);
          check("R6 txd released", txd, 1);
        end else begin
          check("R9 status", got_st, es);
        end
        txs = 1'b0;
      end
      repeat (6) @(negedge clk);
    end

    // R2 no sync reply
    restart();
    fork kp_sync(0, 0); join
    repeat (RESP + 10) @(negedge clk);
    do_req();
    check("R2 status", got_st, 2'b11);
    check("R2 txd high", txd, 1);
    txs = 1'b1;
    repeat (5) @(negedge clk);
    txs = 1'b0;
    repeat (5) @(negedge clk);
    do_req();
    check("R2 stays abandoned", got_st, 2'b11);

    // R3 reply never returns low
    restart();
    kp_sync(1, 0);
    repeat (CORR + 10) @(negedge clk);
    txs = 1'b0;
    repeat (5) @(negedge clk);
    do_req();
    check("R3 status", got_st, 2'b11);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule